// File: doc/BRIEF.md
# Packed Saturating Add/Subtract and Multiply Unit

This block is a 64-bit SIMD integer arithmetic unit. Each operand word is split into eight 8-bit, four 16-bit or two 32-bit lanes. Every lane is added or subtracted on its own, in one of three modes: wraparound, signed saturating or unsigned saturating. The unit can also multiply four 16-bit lanes as signed numbers and return either the low or the high 16 bits of each 32-bit product.

A single partitioned byte-slice carry chain serves all lane sizes. At each lane's lowest byte the carry is cut and replaced by the operation's carry-in. Saturation is chosen per lane from that lane's top-byte carry and sign bits. The result goes into a register, which is loaded only on cycles where the input valid strobe is high.

The unit has no flags and no exceptions. A request for a saturating mode on 32-bit lanes is still legal and is computed as wraparound.

Top module: `simd_arith_unit`

## Requirements
- R1: `op_kind` 00 adds lane-wise. `lane_sz` 00 selects 8-bit lanes, 01 selects 16-bit lanes, and 10 or 11 selects 32-bit lanes. With `sat_mode` 00 (or 11) each lane keeps only the low bits of its sum (wraparound). Lane k occupies bits [k*W+W-1 : k*W].
- R2: `op_kind` 01 subtracts B from A lane-wise. It uses the same lane sizes and modes as addition, and in wraparound mode it returns A-B modulo 2^W.
- R3: `sat_mode` 01 on 8- or 16-bit lanes is signed saturation. A result above the lane's maximum becomes 0x7F / 0x7FFF, and a result below the lane's minimum becomes 0x80 / 0x8000.
- R4: `sat_mode` 10 on 8- or 16-bit lanes is unsigned saturation. Overflow becomes 0xFF / 0xFFFF and underflow becomes zero.
- R5: No carry or borrow crosses a lane boundary in any mode or lane size.
- R6: A saturating mode (01 or 10) on 32-bit lanes returns the wraparound result.
- R7: `op_kind` 10 multiplies the four 16-bit lanes and returns the low 16 bits of each product. This equals the low half of the unsigned product. `lane_sz` and `sat_mode` are ignored.
- R8: `op_kind` 11 multiplies the four 16-bit lanes as signed numbers and returns bits [31:16] of each product.
- R9: `out_valid` equals `in_valid` delayed by one clock, and `out_data` carries the result of the operands presented one clock earlier.
- R10: Reset clears `out_data` and `out_valid` to zero. While `in_valid` is low, `out_data` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; loads the result register |
| op_kind | input | 2 | 00 add, 01 subtract, 10 multiply low, 11 multiply high |
| lane_sz | input | 2 | 00 8-bit, 01 16-bit, 1x 32-bit lanes |
| sat_mode | input | 2 | 00 wrap, 01 signed sat, 10 unsigned sat, 11 wrap |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 64 | Registered result |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid latency and the hold of the result while no request is present;
- byte isolation for 8-bit wraparound adds;
- the wraparound result for saturating requests on 32-bit lanes;
- that unsigned saturating byte adds never fall below operand A;
- that signed 16-bit saturating adds of two non-negative lanes stay non-negative;
- that the low multiply half matches the unsigned product.

The exact clamp values, the high product half and subtraction across every lane size are shown only by the bench scenarios. Those scenarios compare against an independent lane-by-lane integer model, using directed boundary operands and seeded random traffic.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {K_ADD = 2'b00, K_SUB = 2'b01, K_MULLO = 2'b10, K_MULHI = 2'b11} op_kind_e;
  typedef enum logic [1:0] {SZ_B8 = 2'b00, SZ_H16 = 2'b01, SZ_W32 = 2'b10, SZ_W32B = 2'b11} lane_sz_e;
  typedef enum logic [1:0] {M_WRAP = 2'b00, M_SSAT = 2'b01, M_USAT = 2'b10, M_WRAP2 = 2'b11} sat_mode_e;

  localparam int unsigned SLICE_W = 8;

  // True when byte idx is the lowest byte of its lane.
  function automatic logic lane_base(input int unsigned idx, input logic [1:0] sz);
    if (sz == SZ_B8)       lane_base = 1'b1;
    else if (sz == SZ_H16) lane_base = (idx % 2) == 0;
    else                   lane_base = (idx % 4) == 0;
  endfunction

  // Index of the most significant byte of the lane holding byte idx.
  function automatic int unsigned lane_top(input int unsigned idx, input logic [1:0] sz);
    if (sz == SZ_B8)       lane_top = idx;
    else if (sz == SZ_H16) lane_top = idx | 1;
    else                   lane_top = idx | 3;
  endfunction

  // Saturation mode that actually applies: none for 32-bit lanes.
  function automatic logic [1:0] eff_mode(input logic [1:0] sz, input logic [1:0] md);
    if (sz[1] || md == M_WRAP2) eff_mode = M_WRAP;
    else                        eff_mode = md;
  endfunction

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [1:0]        sz,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] res,
  output logic [DATA_W/SLICE_W-1:0] sat_hit
);
  localparam int unsigned NB = DATA_W / SLICE_W;

  logic [DATA_W-1:0]   bx;
  logic [DATA_W-1:0]   raw;
  logic [NB-1:0]       cin;
  logic [NB-1:0]       cout;
  logic [1:0]          emode;

  assign bx    = b ^ {DATA_W{sub}};
  assign emode = eff_mode(sz, mode);

  // Partitioned carry chain: carry cut at each lane's lowest byte.
  always_comb begin
    logic               c;
    logic [SLICE_W:0]   t;
    c = sub;
    for (int i = 0; i < NB; i++) begin
      cin[i] = lane_base(i, sz) ? sub : c;
      t = {1'b0, a[i*SLICE_W +: SLICE_W]} + {1'b0, bx[i*SLICE_W +: SLICE_W]} + {{SLICE_W{1'b0}}, cin[i]};
      raw[i*SLICE_W +: SLICE_W] = t[SLICE_W-1:0];
      cout[i] = t[SLICE_W];
      c = t[SLICE_W];
    end
  end

  // Per-byte saturation from the owning lane's top-byte status.
  always_comb begin
    int unsigned tp;
    logic am, bm, sm, sovf, uovf, tbyte;
    for (int i = 0; i < NB; i++) begin
      tp    = lane_top(i, sz);
      am    = a[tp*SLICE_W + SLICE_W-1];
      bm    = bx[tp*SLICE_W + SLICE_W-1];
      sm    = raw[tp*SLICE_W + SLICE_W-1];
      sovf  = (am == bm) && (sm != am);
      uovf  = sub ? !cout[tp] : cout[tp];
      tbyte = (tp == i);
      sat_hit[i] = ((emode == M_SSAT) && sovf) || ((emode == M_USAT) && uovf);
      if (!sat_hit[i])
        res[i*SLICE_W +: SLICE_W] = raw[i*SLICE_W +: SLICE_W];
      else if (emode == M_USAT)
        res[i*SLICE_W +: SLICE_W] = sub ? {SLICE_W{1'b0}} : {SLICE_W{1'b1}};
      else if (!am)
        res[i*SLICE_W +: SLICE_W] = tbyte ? {1'b0, {(SLICE_W-1){1'b1}}} : {SLICE_W{1'b1}};
      else
        res[i*SLICE_W +: SLICE_W] = tbyte ? {1'b1, {(SLICE_W-1){1'b0}}} : {SLICE_W{1'b0}};
    end
  end

  // R5: a lane base never takes a carry other than the operation carry-in.
  always_comb begin
    for (int i = 0; i < NB; i++)
      if (lane_base(i, sz))
        p_base_cin_r5: assert (cin[i] == sub);
  end

endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              hi_sel,
  output logic [DATA_W-1:0] res
);
  localparam int unsigned NL = DATA_W / LANE_W;

  logic [2*LANE_W-1:0] prod [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic signed [LANE_W-1:0]   sa, sb;
    logic signed [2*LANE_W-1:0] sp;
    assign sa = a[l*LANE_W +: LANE_W];
    assign sb = b[l*LANE_W +: LANE_W];
    assign sp = sa * sb;
    assign prod[l] = sp;
    assign res[l*LANE_W +: LANE_W] = hi_sel ? prod[l][2*LANE_W-1:LANE_W] : prod[l][LANE_W-1:0];

    // R7: low half equals the low half of the unsigned product.
    logic [2*LANE_W-1:0] up;
    assign up = {{LANE_W{1'b0}}, a[l*LANE_W +: LANE_W]} * {{LANE_W{1'b0}}, b[l*LANE_W +: LANE_W]};
    always_comb p_lo_unsigned_r7: assert (prod[l][LANE_W-1:0] == up[LANE_W-1:0]);
  end

endmodule

// File: rtl/simd_arith_unit.sv
module simd_arith_unit
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_kind,
  input  logic [1:0]        lane_sz,
  input  logic [1:0]        sat_mode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned NB = DATA_W / SLICE_W;
  localparam int unsigned NH = DATA_W / 16;
  localparam int unsigned NW = DATA_W / 32;

  logic [DATA_W-1:0] as_res, mul_res, nxt;
  logic [NB-1:0]     sat_hit;
  logic              is_mul;

  assign is_mul = op_kind[1];

  simd_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(op_a), .b(op_b), .sub(op_kind == K_SUB), .sz(lane_sz), .mode(sat_mode),
    .res(as_res), .sat_hit(sat_hit)
  );

  simd_mul16 #(.DATA_W(DATA_W), .LANE_W(16)) u_mul (
    .a(op_a), .b(op_b), .hi_sel(op_kind == K_MULHI), .res(mul_res)
  );

  assign nxt = is_mul ? mul_res : as_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end

  // R9: one-cycle valid latency.
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R10: result holds without a request.
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R6: saturating add on 32-bit lanes wraps.
  for (genvar w = 0; w < NW; w++) begin : g_w32
    p_w32_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_kind == K_ADD && lane_sz[1]) |=>
      out_data[w*32 +: 32] == 32'($past(op_a[w*32 +: 32]) + $past(op_b[w*32 +: 32])));
  end

  // R5 / R4: byte lanes isolated; unsigned saturating add never below A.
  for (genvar i = 0; i < NB; i++) begin : g_byte
    p_byte_iso_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_kind == K_ADD && lane_sz == SZ_B8 && sat_mode == M_WRAP) |=>
      out_data[i*8 +: 8] == 8'($past(op_a[i*8 +: 8]) + $past(op_b[i*8 +: 8])));
    p_usat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_kind == K_ADD && lane_sz == SZ_B8 && sat_mode == M_USAT) |=>
      out_data[i*8 +: 8] >= $past(op_a[i*8 +: 8]));
  end

  // R3: two non-negative 16-bit lanes never produce a negative saturated sum.
  for (genvar h = 0; h < NH; h++) begin : g_half
    p_ssat_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_kind == K_ADD && lane_sz == SZ_H16 && sat_mode == M_SSAT &&
       !op_a[h*16+15] && !op_b[h*16+15]) |=> !out_data[h*16+15]);
  end

endmodule

// File: tb/simd_arith_unit_tb.sv
module simd_arith_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_kind = 2'b00, lane_sz = 2'b00, sat_mode = 2'b00;
  logic [63:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [63:0] out_data;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  simd_arith_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
    .lane_sz(lane_sz), .sat_mode(sat_mode), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(input logic [1:0] k, input logic [1:0] sz,
                                        input logic [1:0] md, input logic [63:0] a,
                                        input logic [63:0] b);
    int w;
    longint msk, ua, ub, sa, sb, r, lo, hi;
    logic [63:0] acc;
    acc = '0;
    w = k[1] ? 16 : (sz == 2'b00 ? 8 : (sz == 2'b01 ? 16 : 32));
    msk = (longint'(1) <<< w) - 1;
    for (int l = 0; l < 64 / w; l++) begin
      ua = longint'((a >> (l * w)) & 64'(msk));
      ub = longint'((b >> (l * w)) & 64'(msk));
      sa = (ua > (msk >>> 1)) ? ua - msk - 1 : ua;
      sb = (ub > (msk >>> 1)) ? ub - msk - 1 : ub;
      if (k == 2'b10)      r = sa * sb;
      else if (k == 2'b11) r = (sa * sb) >>> 16;
      else if (w == 32 || md == 2'b00 || md == 2'b11)
        r = (k == 2'b01) ? ua - ub : ua + ub;
      else if (md == 2'b01) begin
        r  = (k == 2'b01) ? sa - sb : sa + sb;
        hi = msk >>> 1; lo = -hi - 1;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
      end else begin
        r = (k == 2'b01) ? ua - ub : ua + ub;
        if (r > msk) r = msk;
        if (r < 0)   r = 0;
      end
      acc = acc | ((64'(r) & 64'(msk)) << (l * w));
    end
    return acc;
  endfunction

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run(input logic [1:0] k, input logic [1:0] sz, input logic [1:0] md,
                     input logic [63:0] a, input logic [63:0] b, input string req);
    @(negedge clk);
    op_kind = k; lane_sz = sz; sat_mode = md; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_data, model(k, sz, md, a, b), req);
    check({63'd0, out_valid}, 64'd1, {req, "/R9 valid"});
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(out_data, 64'd0, "R10 reset data");
    check({63'd0, out_valid}, 64'd0, "R10 reset valid");
    rst_n = 1'b1;

    // R1 / R5: all-ones bytes plus one wrap per lane without rippling
    run(2'b00, 2'b00, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R1 R5 byte wrap");
    check(out_data, 64'd0, "R5 byte isolation literal");
    run(2'b00, 2'b01, 2'b00, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R1 half add");
    check(out_data, 64'h0100_0100_0100_0100, "R5 half carry literal");
    run(2'b00, 2'b10, 2'b00, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, "R1 R5 word wrap");
    // R2: borrows stay in lanes
    run(2'b01, 2'b00, 2'b00, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, "R2 R5 byte borrow");
    check(out_data, 64'hFFFF_FFFF_FFFF_FFFF, "R2 borrow literal");
    run(2'b01, 2'b10, 2'b00, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, "R2 R5 word borrow");
    // R3: signed clamps
    run(2'b00, 2'b01, 2'b01, 64'h7FFF_7FFF_0001_8000, 64'h0001_7FFF_0001_FFFF, "R3 half ssat add");
    check(out_data, 64'h7FFF_7FFF_0002_8000, "R3 half clamp literal");
    run(2'b01, 2'b00, 2'b01, 64'h8080_7F7F_0000_0000, 64'h0101_8080_0101_7F7F, "R3 byte ssat sub");
    // R4: unsigned clamps
    run(2'b00, 2'b00, 2'b10, 64'hF0F0_0000_0000_00F0, 64'h2020_0000_0000_0010, "R4 byte usat add");
    check(out_data, 64'hFFFF_0000_0000_00FF, "R4 byte clamp literal");
    run(2'b01, 2'b01, 2'b10, 64'h0010_0030_0000_FFFF, 64'h0020_0010_0001_0001, "R4 half usat sub");
    check(out_data, 64'h0000_0020_0000_FFFE, "R4 underflow literal");
    // R6: saturating on 32-bit lanes wraps
    run(2'b00, 2'b10, 2'b01, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R6 w32 ssat");
    check(out_data, 64'h8000_0000_0000_0000, "R6 wrap literal");
    run(2'b01, 2'b11, 2'b10, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, "R6 w32 usat sub");
    // R7 / R8: multiply halves
    run(2'b10, 2'b00, 2'b01, 64'hFFFF_8000_0003_7FFF, 64'hFFFF_8000_FFFE_7FFF, "R7 mul lo");
    check(out_data, 64'h0001_0000_FFFA_0001, "R7 lo literal");
    run(2'b11, 2'b10, 2'b10, 64'hFFFF_8000_0003_7FFF, 64'hFFFF_8000_FFFE_7FFF, "R8 mul hi");
    check(out_data, 64'h0000_4000_FFFF_3FFF, "R8 hi literal");

    // R10: hold while idle, inputs moving
    held = out_data;
    @(negedge clk);
    op_a = 64'h1234_5678_9ABC_DEF0; op_kind = 2'b00;
    @(negedge clk);
    check(out_data, held, "R10 hold");
    check({63'd0, out_valid}, 64'd0, "R9 idle valid");

    // Random traffic across all opcodes
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      logic [1:0]  rk, rs, rm;
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      rk = 2'($urandom); rs = 2'($urandom); rm = 2'($urandom);
      if (i % 5 == 0) rb = ra ^ 64'h8080_8080_8080_8080;
      run(rk, rs, rm, ra, rb, "R1 R2 R3 R4 R6 R7 R8 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule